// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small field-configurable logic array. It builds each output as a sum of product terms. Every input variable gives a true literal and a complemented literal to an AND plane. Each row of that plane is one product term, and the row's fuse bits choose which literals the term uses. An OR plane then merges the product terms into outputs. In fixed-sum mode each output takes a hard-wired group of terms. In programmable-sum mode each output takes whatever set of terms its own OR row selects. Each sum then passes through an XOR stage with a polarity bit. The result goes to a pin driver with its own output-enable bit. The pin's input value is fed back into the AND plane as an extra variable, so a pin whose driver is off acts as an extra input.

A fuse bit of 1 means the fuse is intact and the connection is made. Reset makes every fuse intact, which gives every product term a contradiction, so every sum is 0 until the array is programmed. A synchronous word port writes the AND rows, the OR rows and a control word. The same port reads these words back. Setting a sticky lock bit stops all readback, and only a reset clears that bit. The evaluation path from `in_i` and `pin_i` to `pin_o` is purely combinational.

Top module: `sop_logic_array`

## Requirements
- R1: While `rst_n` is low, every AND and OR fuse is set to 1 and the control word is cleared. After reset, `pin_o` and `pin_oe` are therefore 0, a read of word 0 returns all ones in its low 2*(N_IN+N_OUT) bits, and a read of the control word returns 0.
- R2: Variable v (0..N_IN-1 is `in_i[v]`, N_IN+k is `pin_i[k]`) has its true literal at AND-row bit 2v and its complemented literal at bit 2v+1. A product term is the AND of its connected literals. A row with both literals of any variable connected is 0. A row with no literal connected is 1.
- R3: In fixed-sum mode (control bit 2*N_OUT = 0), output k sums terms k*PAL_GRP to k*PAL_GRP+PAL_GRP-1, and its OR-row bits have no effect.
- R4: In programmable-sum mode (control bit 2*N_OUT = 1), output k sums every term t whose bit t is 1 in OR row k, which is at word address N_PT+k.
- R5: `pin_o[k]` is the sum of output k XORed with control bit k. A polarity bit of 1 inverts that output.
- R6: `pin_oe[k]` equals control bit N_OUT+k. The value on `pin_i[k]` reaches the AND plane as variable N_IN+k whether or not the driver is enabled.
- R7: `pin_o` follows `in_i` and `pin_i` combinationally, with no clock. A configuration write changes the outputs from the rising edge that samples `cfg_we`.
- R8: `cfg_rdata` shows the addressed word one cycle after `cfg_re` and holds its value while `cfg_re` is low. Addresses 0..N_PT-1 are AND rows, N_PT..N_PT+N_OUT-1 are OR rows, N_PT+N_OUT is the control word, and higher addresses read as 0.
- R9: Control bit 2*N_OUT+1 is the lock. Writing it with 1 sets it. Once set, every read returns 0 and writing 0 does not clear it; only reset does. Evaluation and writes keep working while the lock is set.
- R10: A write to an address above the control word changes no stored word and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, restores all fuses |
| in_i | input | N_IN | Dedicated array inputs |
| pin_i | input | N_OUT | Value seen at each pin, fed back as extra variables |
| pin_o | output | N_OUT | Output value after the polarity stage |
| pin_oe | output | N_OUT | Driver enable for each pin |
| cfg_addr | input | AW | Configuration word address |
| cfg_wdata | input | DW | Configuration write data |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | DW | Readback word, valid one cycle after `cfg_re` |

## Verification
The array outputs are combinational, so a result is due in the same cycle as its stimulus. The bench changes `in_i` and `pin_i` just after a falling edge and samples `pin_o` one nanosecond later, with no rising edge in between. A configuration word takes effect on the rising edge inside the write task, so outputs are checked only after the task has returned at the following falling edge. Readback data is registered: the bench raises `cfg_re` at a falling edge and samples `cfg_rdata` at the next falling edge, half a cycle after the edge that loads it.

// File: rtl/sop_pkg.sv
package sop_pkg;

   // Selects how the OR plane gathers its product terms.
   typedef enum logic {
      MODE_FIXED = 1'b0,
      MODE_PROG  = 1'b1
   } or_mode_e;

   // Bit positions inside the control word, derived from the output count.
   function automatic int ctl_mode_bit(input int n_out);
      return 2 * n_out;
   endfunction

   function automatic int ctl_lock_bit(input int n_out);
      return 2 * n_out + 1;
   endfunction

endpackage

// File: rtl/sop_fuse_store.sv
module sop_fuse_store
   import sop_pkg::*;
#(
   parameter int N_PT  = 16,
   parameter int N_OUT = 4,
   parameter int LIT_W = 24,
   parameter int DW    = 32,
   parameter int AW    = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [AW-1:0]                    cfg_addr,
   input  logic [DW-1:0]                    cfg_wdata,
   input  logic                             cfg_we,
   input  logic                             cfg_re,
   output logic [DW-1:0]                    cfg_rdata,
   output logic [N_PT-1:0][LIT_W-1:0]       and_fuse_o,
   output logic [N_OUT-1:0][N_PT-1:0]       or_fuse_o,
   output logic [N_OUT-1:0]                 pol_o,
   output logic [N_OUT-1:0]                 oe_o,
   output or_mode_e                         mode_o
);

   localparam int A_OR  = N_PT;
   localparam int A_CTL = N_PT + N_OUT;
   localparam int MB    = ctl_mode_bit(N_OUT);
   localparam int LB    = ctl_lock_bit(N_OUT);

   logic [N_OUT-1:0] pol_q;
   logic [N_OUT-1:0] oe_q;
   or_mode_e         mode_q;
   logic             lock_q;
   logic [DW-1:0]    rd_word;

   // One register row per product term.
   for (genvar t = 0; t < N_PT; t++) begin : g_and_row
      logic [LIT_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q <= '1;
         else if (cfg_we && (cfg_addr == AW'(t)))
            row_q <= cfg_wdata[LIT_W-1:0];
      end
      assign and_fuse_o[t] = row_q;
   end

   // One register row per output sum.
   for (genvar k = 0; k < N_OUT; k++) begin : g_or_row
      logic [N_PT-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q <= '1;
         else if (cfg_we && (cfg_addr == AW'(A_OR + k)))
            row_q <= cfg_wdata[N_PT-1:0];
      end
      assign or_fuse_o[k] = row_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_q  <= '0;
         oe_q   <= '0;
         mode_q <= MODE_FIXED;
         lock_q <= 1'b0;
      end else if (cfg_we && (cfg_addr == AW'(A_CTL))) begin
         pol_q  <= cfg_wdata[N_OUT-1:0];
         oe_q   <= cfg_wdata[2*N_OUT-1:N_OUT];
         mode_q <= or_mode_e'(cfg_wdata[MB]);
         lock_q <= lock_q | cfg_wdata[LB];
      end
   end

   always_comb begin
      rd_word = '0;
      for (int t = 0; t < N_PT; t++)
         if (cfg_addr == AW'(t))
            rd_word[LIT_W-1:0] = and_fuse_o[t];
      for (int k = 0; k < N_OUT; k++)
         if (cfg_addr == AW'(A_OR + k))
            rd_word[N_PT-1:0] = or_fuse_o[k];
      if (cfg_addr == AW'(A_CTL)) begin
         rd_word[N_OUT-1:0]       = pol_q;
         rd_word[2*N_OUT-1:N_OUT] = oe_q;
         rd_word[MB]              = mode_q;
         rd_word[LB]              = lock_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_rdata <= '0;
      else if (cfg_re)
         cfg_rdata <= lock_q ? '0 : rd_word;
   end

   assign pol_o  = pol_q;
   assign oe_o   = oe_q;
   assign mode_o = mode_q;

   // R9: the lock never falls while reset is inactive.
   a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R9: a read issued while locked returns zero.
   a_r9_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && cfg_re) |=> (cfg_rdata == '0));

   // R8: readback holds while no read is requested.
   a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_re |=> $stable(cfg_rdata));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
   parameter int N_VAR = 12,
   parameter int N_PT  = 16
) (
   input  logic [N_VAR-1:0]               var_i,
   input  logic [N_PT-1:0][2*N_VAR-1:0]   fuse_i,
   output logic [N_PT-1:0]                term_o
);

   localparam int LIT_W = 2 * N_VAR;

   // Literal stage: true at even bits, complement at odd bits.
   logic [LIT_W-1:0] lit;
   for (genvar v = 0; v < N_VAR; v++) begin : g_lit
      assign lit[2*v]   = var_i[v];
      assign lit[2*v+1] = ~var_i[v];
   end

   for (genvar t = 0; t < N_PT; t++) begin : g_term
      // A disconnected literal contributes a 1 to the product.
      assign term_o[t] = &(lit | ~fuse_i[t]);

      logic contra;
      always_comb begin
         contra = 1'b0;
         for (int v = 0; v < N_VAR; v++)
            contra = contra | (fuse_i[t][2*v] & fuse_i[t][2*v+1]);
         // R2: a row holding a literal and its complement is always 0.
         if (contra)
            a_r2_contradiction_zero: assert (term_o[t] == 1'b0);
      end
   end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
   import sop_pkg::*;
#(
   parameter int N_PT    = 16,
   parameter int N_OUT   = 4,
   parameter int PAL_GRP = 4
) (
   input  logic [N_PT-1:0]              term_i,
   input  logic [N_OUT-1:0][N_PT-1:0]   or_fuse_i,
   input  or_mode_e                     mode_i,
   input  logic [N_OUT-1:0]             pol_i,
   output logic [N_OUT-1:0]             out_o
);

   for (genvar k = 0; k < N_OUT; k++) begin : g_sum
      logic fixed_sum;
      logic prog_sum;
      logic sum;

      assign fixed_sum = |term_i[k*PAL_GRP +: PAL_GRP];
      assign prog_sum  = |(term_i & or_fuse_i[k]);
      assign sum       = (mode_i == MODE_PROG) ? prog_sum : fixed_sum;
      assign out_o[k]  = sum ^ pol_i[k];

      // R3 and R5: an idle fixed group leaves only the polarity bit.
      always_comb begin
         if ((mode_i == MODE_FIXED) && (term_i[k*PAL_GRP +: PAL_GRP] == '0))
            a_r3_idle_group: assert (out_o[k] == pol_i[k]);
      end
   end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array
   import sop_pkg::*;
#(
   parameter int N_IN    = 8,
   parameter int N_OUT   = 4,
   parameter int N_PT    = 16,
   parameter int PAL_GRP = 4,
   parameter int DW      = 32,
   parameter int AW      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_IN-1:0]   in_i,
   input  logic [N_OUT-1:0]  pin_i,
   output logic [N_OUT-1:0]  pin_o,
   output logic [N_OUT-1:0]  pin_oe,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [DW-1:0]     cfg_wdata,
   input  logic              cfg_we,
   input  logic              cfg_re,
   output logic [DW-1:0]     cfg_rdata
);

   localparam int N_VAR   = N_IN + N_OUT;
   localparam int LIT_W   = 2 * N_VAR;
   localparam int N_WORDS = N_PT + N_OUT + 1;

   // Elaboration-time parameter checks.
   if (DW < LIT_W)                 $error("DW too narrow for an AND row");
   if (DW < N_PT)                  $error("DW too narrow for an OR row");
   if (DW < 2 * N_OUT + 2)         $error("DW too narrow for the control word");
   if ((1 << AW) < N_WORDS)        $error("AW too narrow for the word map");
   if (N_OUT * PAL_GRP > N_PT)     $error("fixed groups exceed the term count");
   if (PAL_GRP < 1)                $error("PAL_GRP must be positive");

   logic [N_PT-1:0][LIT_W-1:0]   and_fuse;
   logic [N_OUT-1:0][N_PT-1:0]   or_fuse;
   logic [N_OUT-1:0]             pol;
   logic [N_OUT-1:0]             oe;
   or_mode_e                     mode;
   logic [N_PT-1:0]              term;

   sop_fuse_store #(
      .N_PT  (N_PT),
      .N_OUT (N_OUT),
      .LIT_W (LIT_W),
      .DW    (DW),
      .AW    (AW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_we     (cfg_we),
      .cfg_re     (cfg_re),
      .cfg_rdata  (cfg_rdata),
      .and_fuse_o (and_fuse),
      .or_fuse_o  (or_fuse),
      .pol_o      (pol),
      .oe_o       (oe),
      .mode_o     (mode)
   );

   sop_and_plane #(
      .N_VAR (N_VAR),
      .N_PT  (N_PT)
   ) u_and (
      .var_i  ({pin_i, in_i}),
      .fuse_i (and_fuse),
      .term_o (term)
   );

   sop_or_plane #(
      .N_PT    (N_PT),
      .N_OUT   (N_OUT),
      .PAL_GRP (PAL_GRP)
   ) u_or (
      .term_i    (term),
      .or_fuse_i (or_fuse),
      .mode_i    (mode),
      .pol_i     (pol),
      .out_o     (pin_o)
   );

   assign pin_oe = oe;

   // R6: driver enables move only on a configuration write.
   a_r6_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(pin_oe));

   // R10: a write beyond the control word leaves the enables alone.
   a_r10_oob_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (int'(cfg_addr) >= N_WORDS)) |=> $stable(pin_oe));

endmodule

// File: tb/sop_logic_array_bench.sv
module sop_logic_array_bench;

   localparam int N_IN  = 8;
   localparam int N_OUT = 4;
   localparam int DW    = 32;
   localparam int AW    = 5;
   localparam int A_CTL = 20;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_IN-1:0]  in_i = '0;
   logic [N_OUT-1:0] pin_i = '0;
   logic [N_OUT-1:0] pin_o;
   logic [N_OUT-1:0] pin_oe;
   logic [AW-1:0]    cfg_addr = '0;
   logic [DW-1:0]    cfg_wdata = '0;
   logic             cfg_we = 1'b0;
   logic             cfg_re = 1'b0;
   logic [DW-1:0]    cfg_rdata;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sop_logic_array u_sop_logic_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_i      (in_i),
      .pin_i     (pin_i),
      .pin_o     (pin_o),
      .pin_oe    (pin_oe),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_we    (cfg_we),
      .cfg_re    (cfg_re),
      .cfg_rdata (cfg_rdata)
   );

   // Fixed-mode vectors: {in[7:0], pin[3:0], expected pin_o[3:0]}.
   localparam logic [15:0] VEC [7] = '{
      {8'h00, 4'b0000, 4'b0100},
      {8'h01, 4'b0000, 4'b0101},
      {8'h1F, 4'b0000, 4'b0110},
      {8'h60, 4'b0000, 4'b0000},
      {8'h80, 4'b0001, 4'b1100},
      {8'h80, 4'b1110, 4'b0100},
      {8'h16, 4'b0000, 4'b0111}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      @(negedge clk);
      cfg_addr  = AW'(addr);
      cfg_wdata = data;
      cfg_we    = 1'b1;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data);
      @(negedge clk);
      cfg_addr = AW'(addr);
      cfg_re   = 1'b1;
      @(negedge clk);
      cfg_re   = 1'b0;
      data     = cfg_rdata;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic logic [31:0] lit(input int v, input int comp);
      return 32'(1) << (2 * v + comp);
   endfunction

   // Intended functions of the programmed array.
   function automatic logic [3:0] model(input logic prog, input logic [7:0] a, input logic [3:0] p);
      logic x;
      logic mj;
      x  = a[0] ^ a[1];
      mj = (a[2] & a[3]) | (a[2] & a[4]) | (a[3] & a[4]);
      if (!prog)
         return {p[0] & a[7], ~(a[5] & a[6]), mj, x};
      return {1'b1, mj, ~x, x};
   endfunction

   initial begin
      #1_000_000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      apply_reset();

      // R1: reset state.
      @(negedge clk); #1;
      chk("R1 pin_o", 32'(pin_o), 32'h0);
      chk("R1 pin_oe", 32'(pin_oe), 32'h0);
      rd(0, r);  chk("R1 R8 term0 fuses", r, 32'h00FF_FFFF);
      rd(A_CTL, r); chk("R1 ctl word", r, 32'h0);
      rd(16, r); chk("R1 or row0", r, 32'h0000_FFFF);

      // R2: all-intact rows give 0 for any inputs.
      @(negedge clk); in_i = 8'hA5; pin_i = 4'hF; #1;
      chk("R2 contradiction", 32'(pin_o), 32'h0);

      // Program fixed-mode functions.
      wr(0, lit(0,0) | lit(1,1));
      wr(1, lit(0,1) | lit(1,0));
      wr(4, lit(2,0) | lit(3,0));
      wr(5, lit(2,0) | lit(4,0));
      wr(6, lit(3,0) | lit(4,0));
      wr(8, lit(5,0) | lit(6,0));
      wr(12, lit(8,0) | lit(7,0));
      wr(A_CTL, 32'h0000_0054);
      rd(0, r); chk("R8 readback term0", r, lit(0,0) | lit(1,1));
      rd(A_CTL, r); chk("R8 readback ctl", r, 32'h0000_0054);
      @(negedge clk); #1;
      chk("R6 pin_oe pattern", 32'(pin_oe), 32'h5);

      // R3 R5 R6 R7: directed vector table.
      foreach (VEC[i]) begin
         @(negedge clk);
         in_i  = VEC[i][15:8];
         pin_i = VEC[i][7:4];
         #1;
         chk("R3 R5 R6 R7 vector", 32'(pin_o), 32'(VEC[i][3:0]));
      end

      // R3: OR row ignored in fixed mode.
      wr(16, 32'h0);
      @(negedge clk); in_i = 8'h01; pin_i = 4'h0; #1;
      chk("R3 or row ignored", 32'(pin_o), 32'h5);

      // R10: out-of-range write has no effect; R8 out-of-range read is 0.
      wr(25, 32'hFFFF_FFFF);
      rd(25, r); chk("R8 R10 oob read", r, 32'h0);
      rd(A_CTL, r); chk("R10 ctl untouched", r, 32'h0000_0054);
      @(negedge clk); #1;
      chk("R10 outputs untouched", 32'(pin_o), 32'h5);

      // R3 R6: full sweep of inputs and pins in fixed mode.
      for (int a = 0; a < 256; a++) begin
         for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            in_i = 8'(a); pin_i = 4'(p); #1;
            chk("R3 fixed sweep", 32'(pin_o), 32'(model(1'b0, 8'(a), 4'(p))));
         end
      end

      // Programmable-sum mode, with an empty term (R2) on term 15.
      wr(15, 32'h0);
      wr(16, 32'h3);
      wr(17, 32'h3);
      wr(18, 32'h70);
      wr(19, 32'h8000);
      wr(A_CTL, 32'h0000_0152);
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         in_i = 8'(a); pin_i = 4'(a); #1;
         chk("R4 R2 R5 prog sweep", 32'(pin_o), 32'(model(1'b1, 8'(a), 4'(a))));
      end

      // R9: lock blocks readback, survives a write of 0, clears on reset.
      wr(A_CTL, 32'h0000_0352);
      rd(0, r); chk("R9 locked term read", r, 32'h0);
      rd(A_CTL, r); chk("R9 locked ctl read", r, 32'h0);
      wr(A_CTL, 32'h0000_0152);
      rd(0, r); chk("R9 lock sticky", r, 32'h0);
      @(negedge clk); in_i = 8'h1D; pin_i = 4'h0; #1;
      chk("R9 eval while locked", 32'(pin_o), 32'(model(1'b1, 8'h1D, 4'h0)));
      apply_reset();
      rd(0, r); chk("R9 R1 unlock by reset", r, 32'h00FF_FFFF);
      @(negedge clk); #1;
      chk("R1 pins after reset", 32'(pin_o), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule